// File: doc/BRIEF.md
# Memory-Card Line Symbol Detector

This block watches the three wires of a synchronous serial memory-card bus: a reset line, a bus clock and a bidirectional data line. The lines are oversampled by a much faster system clock. The block turns the activity on them into a stream of line symbols. The symbols are a true reset, an interrupt, a start condition, a stop condition and data bits. It also packs the data bits into bytes. Every symbol appears on its own single-cycle strobe. Each data bit comes with its level, and each finished byte comes with its value.

A transaction tracker further up the chain consumes these strobes. While the card is sending data or doing internal work, the tracker raises a mask input. The mask hides stop conditions, because the data line then belongs to the card. Start conditions still get through, so the stream can recover after a memory read that ran to the end of the card.

Top module: `mcard_sym_detect`

## Requirements
- R1: When reset falls after a complete bus-clock pulse (a rise and then a fall) while reset was high, `reset_sym` pulses.
- R2: When reset falls and no complete bus-clock pulse occurred while it was high, `intr_sym` pulses instead of `reset_sym`.
- R3: While reset is high, no start, stop or bit strobe is produced.
- R4: A falling data-line edge while the bus clock is high pulses `start_sym`.
- R5: A rising data-line edge while the bus clock is high pulses `stop_sym` when `stop_mask` is 0. It produces nothing when `stop_mask` is 1.
- R6: `stop_mask` has no effect on start conditions.
- R7: With reset low, the data level present at a rising bus-clock edge becomes `bit_val`. `bit_stb` pulses only after the following falling bus-clock edge.
- R8: Every eighth bit pulses `byte_stb` together with `bit_stb`. `byte_val` bit 0 holds the first bit received and bit 7 holds the last.
- R9: Start, stop, reset and interrupt symbols discard any partly collected bits, so the next eight bits form a whole byte.
- R10: When the bus clock and the data line change in the same sample, only the clock edge is acted on. No start or stop is reported.
- R11: A falling bus-clock edge that has no matching rising edge outside reset (for example, one that follows a start condition or a reset release) produces no bit strobe.
- R12: Every strobe lasts exactly one system-clock cycle. At most one of the symbol strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low synchronous reset of the block |
| line_rst | input | 1 | Bus reset line, asynchronous |
| line_clk | input | 1 | Bus clock line, asynchronous |
| line_io | input | 1 | Bus data line, asynchronous |
| stop_mask | input | 1 | 1 = ignore stop conditions (outgoing-data or processing phase) |
| reset_sym | output | 1 | True reset seen (strobe) |
| intr_sym | output | 1 | Interrupt seen (strobe) |
| start_sym | output | 1 | Start condition (strobe) |
| stop_sym | output | 1 | Stop condition (strobe) |
| bit_stb | output | 1 | Data bit completed (strobe) |
| bit_val | output | 1 | Level of the completed bit |
| byte_stb | output | 1 | Byte completed (strobe) |
| byte_val | output | BYTE_BITS | Completed byte, first bit in bit 0 |

## Verification
The hardest case to reach is a bit end with no bit start. From the ports it can only be produced in two ways. One is a start or stop condition arriving between the two clock edges. The other is a reset window that closes while the bus clock is still high. The stimulus builds both sequences on purpose and then sends a full byte to show that the framing is still aligned. A second delicate case is a clock edge and a data edge landing in the same synchronizer sample. The bench gets there by driving both lines on the same system-clock edge.

// File: rtl/mcard_sym_detect.sv
module mcard_sym_detect #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_BITS   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_rst,
  input  logic                 line_clk,
  input  logic                 line_io,
  input  logic                 stop_mask,
  output logic                 reset_sym,
  output logic                 intr_sym,
  output logic                 start_sym,
  output logic                 stop_sym,
  output logic                 bit_stb,
  output logic                 bit_val,
  output logic                 byte_stb,
  output logic [BYTE_BITS-1:0] byte_val
);

  localparam int CNT_W = $clog2(BYTE_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_BITS - 1);

  logic [SYNC_STAGES-1:0][2:0] pipe;
  logic [2:0] cur, prv;
  logic c_rst, c_clk, c_io, p_rst, p_clk, p_io;
  logic rst_rise, rst_fall, clk_rise, clk_fall, io_rise, io_fall;
  logic win_clk_hi, win_pulse, pend, pend_val;
  logic [CNT_W-1:0] cnt;
  logic [BYTE_BITS-1:0] shreg, nxt;

  assign cur = pipe[SYNC_STAGES-1];
  assign {c_rst, c_clk, c_io} = cur;
  assign {p_rst, p_clk, p_io} = prv;
  assign rst_rise = c_rst & ~p_rst;
  assign rst_fall = ~c_rst & p_rst;
  assign clk_rise = c_clk & ~p_clk;
  assign clk_fall = ~c_clk & p_clk;
  assign io_rise  = c_io & ~p_io;
  assign io_fall  = ~c_io & p_io;
  assign nxt      = {pend_val, shreg[BYTE_BITS-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe <= '0;
      prv <= '0;
      {reset_sym, intr_sym, start_sym, stop_sym, bit_stb, byte_stb} <= '0;
      bit_val <= 1'b0;
      byte_val <= '0;
      win_clk_hi <= 1'b0;
      win_pulse <= 1'b0;
      pend <= 1'b0;
      pend_val <= 1'b0;
      cnt <= '0;
      shreg <= '0;
    end else begin
      pipe <= {pipe[SYNC_STAGES-2:0], {line_rst, line_clk, line_io}};
      prv <= cur;
      {reset_sym, intr_sym, start_sym, stop_sym, bit_stb, byte_stb} <= '0;
      if (rst_rise) begin
        win_clk_hi <= 1'b0;
        win_pulse <= 1'b0;
        pend <= 1'b0;
        cnt <= '0;
      end else if (rst_fall) begin
        reset_sym <= win_pulse;
        intr_sym <= ~win_pulse;
        pend <= 1'b0;
        cnt <= '0;
      end else if (c_rst) begin
        if (clk_rise) win_clk_hi <= 1'b1;
        if (clk_fall && win_clk_hi) win_pulse <= 1'b1;
      end else if (clk_rise) begin
        pend <= 1'b1;
        pend_val <= c_io;
      end else if (clk_fall) begin
        pend <= 1'b0;
        if (pend) begin
          bit_stb <= 1'b1;
          bit_val <= pend_val;
          shreg <= nxt;
          if (cnt == LAST) begin
            byte_stb <= 1'b1;
            byte_val <= nxt;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          cnt <= '0;
        end
      end else if (c_clk && io_fall) begin
        start_sym <= 1'b1;
        pend <= 1'b0;
        cnt <= '0;
      end else if (c_clk && io_rise && !stop_mask) begin
        stop_sym <= 1'b1;
        pend <= 1'b0;
        cnt <= '0;
      end
    end
  end

  assert_sym_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reset_sym, intr_sym, start_sym, stop_sym, bit_stb}));

  assert_strobe_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_sym || intr_sym || start_sym || stop_sym || byte_stb) |=>
    !(reset_sym || intr_sym || start_sym || stop_sym || byte_stb));

  assert_byte_with_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |-> bit_stb);

  assert_window_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rst && p_rst) |=> !(start_sym || stop_sym || bit_stb));

  assert_stop_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_mask |=> !stop_sym);

  assert_close_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_sym || intr_sym) |-> $past(p_rst && !c_rst));

endmodule

// File: tb/mcard_sym_detect_tb_top.sv
module mcard_sym_detect_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 4;
  localparam logic [7:0] VEC [0:5] = '{8'h00, 8'hFF, 8'h5A, 8'h81, 8'h37, 8'hC4};

  logic clk = 1'b0, rst_n = 1'b0;
  logic lrst = 1'b0, lclk = 1'b0, lio = 1'b1, smask = 1'b0;
  logic reset_sym, intr_sym, start_sym, stop_sym, bit_stb, bit_val, byte_stb;
  logic [7:0] byte_val;

  int tests = 0, fails = 0;
  int n_rs = 0, n_in = 0, n_st = 0, n_sp = 0, n_bit = 0, n_byte = 0;
  logic last_bit = 1'b0;
  logic [7:0] last_byte = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcard_sym_detect dut_i (
    .clk(clk), .rst_n(rst_n), .line_rst(lrst), .line_clk(lclk), .line_io(lio),
    .stop_mask(smask), .reset_sym(reset_sym), .intr_sym(intr_sym),
    .start_sym(start_sym), .stop_sym(stop_sym), .bit_stb(bit_stb),
    .bit_val(bit_val), .byte_stb(byte_stb), .byte_val(byte_val));

  always @(negedge clk) if (rst_n) begin
    if (reset_sym) n_rs++;
    if (intr_sym) n_in++;
    if (start_sym) n_st++;
    if (stop_sym) n_sp++;
    if (bit_stb) begin n_bit++; last_bit = bit_val; end
    if (byte_stb) begin n_byte++; last_byte = byte_val; end
  end

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic hold();
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic bit_send(input logic b);
    lio = b; hold();
    lclk = 1'b1; hold();
    lclk = 1'b0; hold();
  endtask

  task automatic byte_send(input logic [7:0] v);
    for (int i = 0; i < 8; i++) bit_send(v[i]);
  endtask

  task automatic do_start();
    lclk = 1'b0; lio = 1'b1; hold();
    lclk = 1'b1; hold();
    lio = 1'b0; hold();
    lclk = 1'b0; hold();
  endtask

  task automatic do_stop();
    lclk = 1'b0; lio = 1'b0; hold();
    lclk = 1'b1; hold();
    lio = 1'b1; hold();
    lclk = 1'b0; hold();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int b0, s0, bt0, r0, i0, p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    hold();
    check("R12 reset state strobes", n_rs + n_in + n_st + n_sp + n_bit + n_byte, 0);
    check("R12 reset state byte_val", int'(byte_val), 0);

    for (int k = 0; k < 6; k++) begin
      b0 = n_byte; s0 = n_st; bt0 = n_bit;
      do_start();
      byte_send(VEC[k]);
      check("R4 start count", n_st - s0, 1);
      check("R7 bit count", n_bit - bt0, 8);
      check("R8 byte count", n_byte - b0, 1);
      check("R8 byte value", int'(last_byte), int'(VEC[k]));
    end

    // R7: strobe only after falling edge, value from rising edge
    do_start();
    bt0 = n_bit;
    lio = 1'b1; hold();
    lclk = 1'b1; hold();
    lio = 1'b0; hold(); // start condition here: drops the bit
    lclk = 1'b0; hold();
    lio = 1'b1; hold();
    lclk = 1'b1; hold();
    check("R7 no strobe before fall", n_bit - bt0, 0);
    lclk = 1'b0; hold();
    check("R7 strobe after fall", n_bit - bt0, 1);
    check("R7 bit value", int'(last_bit), 1);

    // R5 / R6 stop masking
    p0 = n_sp;
    smask = 1'b0; do_stop();
    check("R5 stop seen", n_sp - p0, 1);
    smask = 1'b1; do_stop();
    check("R5 stop masked", n_sp - p0, 1);
    s0 = n_st; do_start();
    check("R6 start under mask", n_st - s0, 1);
    smask = 1'b0;

    // R9: partial bits discarded by start and by reset
    do_start();
    bit_send(1); bit_send(1); bit_send(1);
    b0 = n_byte;
    do_start();
    byte_send(8'hA5);
    check("R9 start discard count", n_byte - b0, 1);
    check("R9 start discard value", int'(last_byte), 'hA5);
    bit_send(1); bit_send(0); bit_send(1);
    lrst = 1'b1; hold(); lrst = 1'b0; hold();
    b0 = n_byte;
    byte_send(8'h3C);
    check("R9 reset discard count", n_byte - b0, 1);
    check("R9 reset discard value", int'(last_byte), 'h3C);

    // R1 true reset
    r0 = n_rs; i0 = n_in;
    lrst = 1'b1; hold(); lclk = 1'b1; hold(); lclk = 1'b0; hold();
    lrst = 1'b0; hold();
    check("R1 reset count", n_rs - r0, 1);
    check("R1 no interrupt", n_in - i0, 0);

    // R2 interrupt
    lrst = 1'b1; hold(); lrst = 1'b0; hold();
    check("R2 interrupt count", n_in - i0, 1);
    check("R2 no reset", n_rs - r0, 1);

    // R3 window quiet
    s0 = n_st; p0 = n_sp; bt0 = n_bit;
    lio = 1'b1; lrst = 1'b1; hold();
    lclk = 1'b1; hold(); lio = 1'b0; hold(); lio = 1'b1; hold();
    lclk = 1'b0; hold();
    check("R3 no start/stop in window", (n_st - s0) + (n_sp - p0), 0);
    check("R3 no bit in window", n_bit - bt0, 0);
    lrst = 1'b0; hold();
    check("R3 window closes as reset", n_rs - r0, 2);

    // R10 simultaneous clock and data change
    lclk = 1'b0; lio = 1'b1; hold();
    s0 = n_st; bt0 = n_bit;
    lclk = 1'b1; lio = 1'b0; hold();
    check("R10 no start on same-sample change", n_st - s0, 0);
    lclk = 1'b0; hold();
    check("R10 clock edge taken", n_bit - bt0, 1);
    check("R10 bit value", int'(last_bit), 0);

    // R11 orphan bit end after reset release with clock high
    i0 = n_in; bt0 = n_bit;
    lrst = 1'b1; hold(); lclk = 1'b1; hold();
    lrst = 1'b0; hold();
    lclk = 1'b0; hold();
    check("R11 no bit from orphan fall", n_bit - bt0, 0);
    check("R11 half pulse gives interrupt", n_in - i0, 1);
    b0 = n_byte;
    byte_send(8'h96);
    check("R11 alignment after orphan", n_byte - b0, 1);
    check("R11 value after orphan", int'(last_byte), 'h96);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule